// File: doc/BRIEF.md
# Message-Signaled Interrupt Write Generator

This block turns interrupt events from inside the chip into one posted memory write. The host decodes that write as an interrupt. Software programs three things through a small register port: a 64-bit target address, a 16-bit message value and an enable bit. Each internal source raises a request that carries a 3-bit vector. The block puts that vector into the three low bits of the programmed value and sends the resulting 32-bit word to the programmed address on an outbound write channel with a valid/ready handshake.

Two sources feed the block: an interrupt-coalescing engine and an embedded firmware processor. A round-robin arbiter chooses between them when both are ready. A request is not dropped when it loses arbitration.

The block also tracks the status-block write that precedes every interrupt. A message is held back while a status write is still outstanding, so the interrupt cannot reach the host ahead of the data it announces.

Top module: `msi_gen`

## Requirements
- R1: The configuration registers are written and read through the register port at these offsets:
  - 0x5C: low address word, 32 bits.
  - 0x60: high address word, 32 bits.
  - 0x64: message value, 16 bits. A read returns zero in bits 31:16.
  - 0x68: enable, bit 0.

  All four registers reset to zero. A read of any other offset returns zero.
- R2: The outbound data word is built as follows:
  - Bits 31:16 are zero.
  - Bits 15:3 are the programmed message value.
  - Bits 2:0 are the vector of the source being served.
  - `mw_vec` carries that same vector.
- R3: The outbound address is {high word, low word}. When the high word is zero, address bits 63:32 are zero.
- R4: A status write is outstanding from the cycle `stat_wr_req` is seen until the cycle `stat_done` is seen. While one is outstanding, `mw_valid` does not rise. A `stat_wr_req` in the same cycle as `stat_done` leaves a status write outstanding.
- R5: While the enable bit is 0, no write is issued and requests stay pending. A pending request is issued after the enable bit is set.
- R6: When both sources are eligible in the same cycle, the source that was not granted most recently wins. After reset, source 0 wins. The losing request is issued afterwards.
- R7: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr`, `mw_data` and `mw_vec` hold their values.
- R8: `src_ack` has at most one bit set. Exactly one bit is set in every cycle where `mw_valid` and `mw_ready` are both high, and that bit belongs to the source whose vector is being sent.
- R9: Take an idle source, with the enable bit set and no status write outstanding. If its request is sampled at a clock edge, `mw_valid` is high after the second edge following it and low after the first.
- R10: After reset, `mw_valid` and `src_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| src_req | input | NUM_SRC | Per-source request, held until acknowledged (bit 0 is the coalescing engine, bit 1 is the firmware processor) |
| src_vec | input | NUM_SRC*3 | Per-source message vector, 3 bits each |
| src_ack | output | NUM_SRC | One-cycle acknowledge when the source's write is accepted |
| stat_wr_req | input | 1 | A status-block write has been requested |
| stat_done | input | 1 | The outstanding status-block write has been accepted |
| mw_valid | output | 1 | Outbound message write is valid |
| mw_ready | input | 1 | Downstream accepts the write |
| mw_addr | output | 64 | Message target address |
| mw_data | output | 32 | Message data word |
| mw_vec | output | 3 | Vector carried in the data word |

## Verification
The bench targets these corner cases:
- **Status ordering.** A request is raised in the same cycle as a status write. A design that forgot the ordering rule would launch the message before `stat_done`.
- **Enable bit.** A request is made while the enable bit is clear. A design that dropped held requests would never produce the write after the bit is set.
- **Simultaneous requests.** Both sources request in the same cycle. A fixed-priority arbiter would pick the wrong winner, and a design that lost the loser would never acknowledge it.
- **Back-pressure.** `mw_ready` is held low. A design whose outputs followed live configuration would let the address or data drift.
- **Data word.** The vector table uses message values with nonzero low bits. A design that merged the vector with OR instead of replacing the bits would corrupt bits 2:0.

// File: rtl/msi_pkg.sv
// Shared constants and types for the message write generator.
// Assumes byte offsets on the register port and 32-bit register words.
package msi_pkg;
    localparam int VEC_W = 3;
    localparam int CFG_AW = 8;
    localparam logic [CFG_AW-1:0] OFS_ADDR_LO = 8'h5C;
    localparam logic [CFG_AW-1:0] OFS_ADDR_HI = 8'h60;
    localparam logic [CFG_AW-1:0] OFS_MSG = 8'h64;
    localparam logic [CFG_AW-1:0] OFS_CTRL = 8'h68;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT_STATUS = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DONE = 2'd3
    } src_state_e;
endpackage

// File: rtl/msi_cfg_regs.sv
// Configuration register file: target address (two words), message value
// and enable. Writes take effect at the clock edge; reads are combinational.
// Assumes a single-cycle write strobe and no byte enables.
module msi_cfg_regs
    import msi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [63:0]       tgt_addr,
    output logic [15:0]       msg_val,
    output logic              enable
);
    logic [31:0] lo_q;
    logic [31:0] hi_q;
    logic [15:0] msg_q;
    logic        en_q;

    // Register update on software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            msg_q <= '0;
            en_q  <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                OFS_ADDR_LO: lo_q  <= wdata;
                OFS_ADDR_HI: hi_q  <= wdata;
                OFS_MSG:     msg_q <= wdata[15:0];
                OFS_CTRL:    en_q  <= wdata[0];
                default:     ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            OFS_ADDR_LO: rdata = lo_q;
            OFS_ADDR_HI: rdata = hi_q;
            OFS_MSG:     rdata = {16'h0000, msg_q};
            OFS_CTRL:    rdata = {31'h0, en_q};
            default:     rdata = '0;
        endcase
    end

    assign tgt_addr = {hi_q, lo_q};
    assign msg_val  = msg_q;
    assign enable   = en_q;
endmodule

// File: rtl/msi_src_fsm.sv
// Per-source request tracker. It captures the vector on a new request and
// waits until it is allowed to compete. It then holds the request while its
// write sits in the output slot, and passes through one DONE cycle before it
// will take another request.
// Assumes the source holds req and vec stable until it sees its acknowledge.
module msi_src_fsm
    import msi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [VEC_W-1:0] vec_in,
    input  logic             blocked,
    input  logic             grant,
    input  logic             accept,
    output logic             eligible,
    output logic [VEC_W-1:0] vec_q
);
    src_state_e state_q;

    // State sequencing and vector capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req) begin
                    state_q <= ST_WAIT_STATUS;
                    vec_q   <= vec_in;
                end
                ST_WAIT_STATUS: if (grant) state_q <= ST_ISSUE;
                ST_ISSUE:       if (accept) state_q <= ST_DONE;
                default:        state_q <= ST_IDLE;
            endcase
        end
    end

    // Allowed to compete only once ordering and enable permit.
    assign eligible = (state_q == ST_WAIT_STATUS) && !blocked;
endmodule

// File: rtl/msi_rr_arb.sv
// Round-robin arbiter. Among the eligible sources, it grants the first one
// after the most recent winner, and only when the output slot is free.
// The grant is one-hot or zero. After reset, source 0 has first priority.
module msi_rr_arb #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] elig,
    input  logic         slot_free,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last_q;

    // Search the sources in rotating order, starting after the last winner.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = (int'(last_q) + 1 + i) % N;
            if (!found && slot_free && elig[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    // Remember the most recent winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IW'(N - 1);
        end else begin
            for (int i = 0; i < N; i++) begin
                if (gnt[i]) last_q <= IW'(i);
            end
        end
    end
endmodule

// File: rtl/msi_gen.sv
// Message write generator top. It keeps the configuration registers, tracks
// the outstanding status-block write, arbitrates between the request sources
// and holds one message in an output register until downstream accepts it.
// Assumes at most one status write outstanding at a time. A new message is
// loaded only while the output slot is empty.
module msi_gen
    import msi_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_en,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC*VEC_W-1:0] src_vec,
    output logic [NUM_SRC-1:0]       src_ack,
    input  logic                     stat_wr_req,
    input  logic                     stat_done,
    output logic                     mw_valid,
    input  logic                     mw_ready,
    output logic [63:0]              mw_addr,
    output logic [31:0]              mw_data,
    output logic [VEC_W-1:0]         mw_vec
);
    logic [63:0]        tgt_addr;
    logic [15:0]        msg_val;
    logic               en_q;
    logic               stat_pend_q;
    logic               blocked;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] gnt;
    logic [NUM_SRC-1:0] owner_q;
    logic [NUM_SRC-1:0] accept;
    logic [VEC_W-1:0]   vec_q [NUM_SRC];
    logic [VEC_W-1:0]   win_vec;
    logic               fire;

    msi_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .tgt_addr (tgt_addr),
        .msg_val  (msg_val),
        .enable   (en_q)
    );

    // Status-write tracker: a new request wins over a same-cycle completion.
    always_ff @(posedge clk) begin
        if (!rst_n)           stat_pend_q <= 1'b0;
        else if (stat_wr_req) stat_pend_q <= 1'b1;
        else if (stat_done)   stat_pend_q <= 1'b0;
    end

    assign blocked = stat_pend_q || stat_wr_req || !en_q;
    assign fire    = mw_valid && mw_ready;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign accept[g] = fire && owner_q[g];
        msi_src_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (src_req[g]),
            .vec_in   (src_vec[g*VEC_W +: VEC_W]),
            .blocked  (blocked),
            .grant    (gnt[g]),
            .accept   (accept[g]),
            .eligible (elig[g]),
            .vec_q    (vec_q[g])
        );
    end

    msi_rr_arb #(.N(NUM_SRC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .slot_free (!mw_valid),
        .gnt       (gnt)
    );

    // Select the vector of the granted source.
    always_comb begin
        win_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (gnt[i]) win_vec = vec_q[i];
        end
    end

    // Output slot: load on grant, clear on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_valid <= 1'b0;
            mw_addr  <= '0;
            mw_data  <= '0;
            mw_vec   <= '0;
            owner_q  <= '0;
        end else if (|gnt) begin
            mw_valid <= 1'b1;
            mw_addr  <= tgt_addr;
            mw_data  <= {16'h0000, msg_val[15:VEC_W], win_vec};
            mw_vec   <= win_vec;
            owner_q  <= gnt;
        end else if (fire) begin
            mw_valid <= 1'b0;
            owner_q  <= '0;
        end
    end

    assign src_ack = accept;
endmodule

// File: rtl/msi_gen_chk.sv
// Protocol checker for msi_gen. It rebuilds the status-pending state from
// the ports and checks ordering, gating, stability and acknowledge rules.
module msi_gen_chk #(
    parameter int NUM_SRC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stat_wr_req,
    input logic               stat_done,
    input logic               en,
    input logic               mw_valid,
    input logic               mw_ready,
    input logic [63:0]        mw_addr,
    input logic [31:0]        mw_data,
    input logic [2:0]         mw_vec,
    input logic [NUM_SRC-1:0] src_ack
);
    logic pend_chk;

    // Independent model of the outstanding status write.
    always_ff @(posedge clk) begin
        if (!rst_n)           pend_chk <= 1'b0;
        else if (stat_wr_req) pend_chk <= 1'b1;
        else if (stat_done)   pend_chk <= 1'b0;
    end

    // R4
    status_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_valid) |-> (!$past(pend_chk) && !$past(stat_wr_req)));

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_valid) |-> $past(en));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr)
                                     && $stable(mw_data) && $stable(mw_vec)));

    // R8
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack));

    // R8
    ack_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && mw_ready) |-> ($countones(src_ack) == 1));

    // R2
    data_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid |-> (mw_data[31:16] == 16'h0000 && mw_data[2:0] == mw_vec));
endmodule

bind msi_gen msi_gen_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_wr_req (stat_wr_req),
    .stat_done   (stat_done),
    .en          (en_q),
    .mw_valid    (mw_valid),
    .mw_ready    (mw_ready),
    .mw_addr     (mw_addr),
    .mw_data     (mw_data),
    .mw_vec      (mw_vec),
    .src_ack     (src_ack)
);

// File: tb/sim_msi_gen.sv
// Bench for msi_gen: a vector table walked by one loop, then directed
// tests for reset, ordering, enable gating, arbitration and back-pressure.
module sim_msi_gen;
    localparam int NS = 2;

    typedef struct packed {
        logic        src;
        logic [2:0]  vec;
        logic [15:0] msg;
        logic [31:0] hi;
        logic [31:0] lo;
    } vec_t;

    localparam vec_t TBL [0:5] = '{
        '{src: 1'b0, vec: 3'd5, msg: 16'hABCF, hi: 32'h0,         lo: 32'hFEE0_1000},
        '{src: 1'b1, vec: 3'd0, msg: 16'h4007, hi: 32'h0000_0001, lo: 32'h2000_0040},
        '{src: 1'b0, vec: 3'd7, msg: 16'h0000, hi: 32'hDEAD_BEEF, lo: 32'h0000_0000},
        '{src: 1'b1, vec: 3'd2, msg: 16'hFFFF, hi: 32'h0,         lo: 32'hFFFF_FFFC},
        '{src: 1'b0, vec: 3'd1, msg: 16'h1238, hi: 32'h8000_0000, lo: 32'h0000_1234},
        '{src: 1'b1, vec: 3'd6, msg: 16'h5555, hi: 32'h0,         lo: 32'h0000_0010}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [7:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic [NS-1:0]     src_req = '0;
    logic [NS*3-1:0]   src_vec = '0;
    logic [NS-1:0]     src_ack;
    logic              stat_wr_req = 1'b0;
    logic              stat_done = 1'b0;
    logic              mw_valid;
    logic              mw_ready = 1'b1;
    logic [63:0]       mw_addr;
    logic [31:0]       mw_data;
    logic [2:0]        mw_vec;

    int n_chk = 0;
    int n_fail = 0;
    int last_src = NS - 1;

    always #5 clk = ~clk;

    msi_gen #(.NUM_SRC(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_req(src_req),
        .src_vec(src_vec), .src_ack(src_ack), .stat_wr_req(stat_wr_req),
        .stat_done(stat_done), .mw_valid(mw_valid), .mw_ready(mw_ready),
        .mw_addr(mw_addr), .mw_data(mw_data), .mw_vec(mw_vec)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Wait at falling edges for mw_valid; returns 0 on timeout.
    task automatic wait_valid(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge clk);
            if (mw_valid) seen = 1'b1;
        end
    endtask

    // Check the slot against the expected message, then drop the served request.
    task automatic check_msg(input int s, input logic [2:0] v, input logic [15:0] m,
                             input logic [63:0] a, input string tag);
        logic [31:0] ed;
        ed = {16'h0000, m[15:3], v};
        check(mw_addr == a, {tag, " R3 address"}, mw_addr, a);
        check(mw_data == ed, {tag, " R2 data word"}, 64'(mw_data), 64'(ed));
        check(mw_vec == v, {tag, " R2 vector"}, 64'(mw_vec), 64'(v));
        #1;
        check(src_ack == NS'(1 << s), {tag, " R8 acknowledge"}, 64'(src_ack), 64'(1 << s));
        src_req[s] = 1'b0;
        last_src = s;
    endtask

    task automatic raise(input int s, input logic [2:0] v);
        src_vec[s*3 +: 3] = v;
        src_req[s] = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        logic [31:0] rd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state, R1 reset values
        check(!mw_valid, "R10 valid after reset", 64'(mw_valid), 0);
        check(src_ack == '0, "R10 ack after reset", 64'(src_ack), 0);
        cfg_read(8'h5C, rd);
        check(rd == 0, "R1 low address reset", 64'(rd), 0);
        cfg_read(8'h68, rd);
        check(rd == 0, "R1 enable reset", 64'(rd), 0);

        // R1 readback and the 16-bit width of the message value
        cfg_write(8'h64, 32'hFFFF_FFFF);
        cfg_read(8'h64, rd);
        check(rd == 32'h0000_FFFF, "R1 message register width", 64'(rd), 64'h0000_FFFF);
        cfg_write(8'h60, 32'h1234_5678);
        cfg_read(8'h60, rd);
        check(rd == 32'h1234_5678, "R1 high address readback", 64'(rd), 64'h1234_5678);
        cfg_read(8'h70, rd);
        check(rd == 0, "R1 unmapped offset", 64'(rd), 0);
        cfg_write(8'h68, 32'h1);

        // Vector table walk: R2 R3 R8 R9
        for (int k = 0; k < 6; k++) begin
            cfg_write(8'h5C, TBL[k].lo);
            cfg_write(8'h60, TBL[k].hi);
            cfg_write(8'h64, {16'h0, TBL[k].msg});
            raise(int'(TBL[k].src), TBL[k].vec);
            @(negedge clk);
            check(!mw_valid, "R9 valid low after first edge", 64'(mw_valid), 0);
            @(negedge clk);
            check(mw_valid, "R9 valid high after second edge", 64'(mw_valid), 1);
            check_msg(int'(TBL[k].src), TBL[k].vec, TBL[k].msg,
                      {TBL[k].hi, TBL[k].lo}, "table");
            @(negedge clk);
        end
        cfg_write(8'h60, 32'h0);
        cfg_write(8'h5C, 32'h0000_ABC0);
        cfg_write(8'h64, 32'h0000_0120);

        // R4: request together with a status write; hold until done
        @(negedge clk);
        stat_wr_req = 1'b1;
        raise(0, 3'd3);
        @(negedge clk);
        stat_wr_req = 1'b0;
        repeat (5) @(negedge clk);
        check(!mw_valid, "R4 held while status outstanding", 64'(mw_valid), 0);
        stat_done = 1'b1;
        @(negedge clk);
        stat_done = 1'b0;
        wait_valid(4, seen);
        check(seen, "R4 issued after status done", 64'(seen), 1);
        if (seen) check_msg(0, 3'd3, 16'h0120, 64'h0000_ABC0, "R4");
        @(negedge clk);

        // R4: set and done in the same cycle leaves the status write outstanding
        stat_wr_req = 1'b1;
        @(negedge clk);
        stat_wr_req = 1'b1; stat_done = 1'b1;
        raise(1, 3'd4);
        @(negedge clk);
        stat_wr_req = 1'b0; stat_done = 1'b0;
        repeat (4) @(negedge clk);
        check(!mw_valid, "R4 new request wins over done", 64'(mw_valid), 0);
        stat_done = 1'b1;
        @(negedge clk);
        stat_done = 1'b0;
        wait_valid(4, seen);
        check(seen, "R4 issued after later done", 64'(seen), 1);
        if (seen) check_msg(1, 3'd4, 16'h0120, 64'h0000_ABC0, "R4b");
        @(negedge clk);

        // R5: enable clear holds the request
        cfg_write(8'h68, 32'h0);
        raise(0, 3'd6);
        repeat (6) @(negedge clk);
        check(!mw_valid, "R5 no write while disabled", 64'(mw_valid), 0);
        cfg_write(8'h68, 32'h1);
        if (!mw_valid) wait_valid(4, seen);
        else seen = 1'b1;
        check(seen, "R5 held request issued after enable", 64'(seen), 1);
        if (seen) check_msg(0, 3'd6, 16'h0120, 64'h0000_ABC0, "R5");
        @(negedge clk);

        // R6: simultaneous requests, round-robin winner, loser not dropped
        begin
            int first;
            int second;
            first = (last_src + 1) % NS;
            second = 1 - first;
            raise(0, 3'd1);
            raise(1, 3'd2);
            wait_valid(4, seen);
            check(seen && mw_vec == (first == 0 ? 3'd1 : 3'd2),
                  "R6 round-robin winner", 64'(mw_vec), 64'(first == 0 ? 1 : 2));
            if (seen) check_msg(first, first == 0 ? 3'd1 : 3'd2, 16'h0120,
                                64'h0000_ABC0, "R6 first");
            wait_valid(6, seen);
            check(seen, "R6 loser issued afterwards", 64'(seen), 1);
            if (seen) check_msg(second, second == 0 ? 3'd1 : 3'd2, 16'h0120,
                                64'h0000_ABC0, "R6 second");
            @(negedge clk);
        end

        // R7: back-pressure holds the slot while configuration changes
        mw_ready = 1'b0;
        raise(1, 3'd5);
        wait_valid(4, seen);
        cfg_write(8'h5C, 32'h5555_0000);
        cfg_write(8'h64, 32'h0000_FFF8);
        repeat (3) @(negedge clk);
        check(mw_valid, "R7 valid held under back-pressure", 64'(mw_valid), 1);
        check(src_ack == '0, "R8 no ack while not ready", 64'(src_ack), 0);
        mw_ready = 1'b1;
        check_msg(1, 3'd5, 16'h0120, 64'h0000_ABC0, "R7");
        @(negedge clk);
        @(negedge clk);
        check(!mw_valid, "R8 slot empties after accept", 64'(mw_valid), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule